// File: doc/BRIEF.md
# Serial Peripheral Master with Word-Scaled Queues

This block is a serial peripheral interface master that a processor drives through a small memory-mapped register port. Software picks a word width of 8, 16 or 32 bits, clock polarity, clock phase and receive sample point, and a 9-bit divider for the serial clock. Words written to the data register are queued for transmission. Each word shifts out most significant bit first while the word coming back on the input line is collected into a receive queue, which software drains by reading the same data register.

Both queues hold a fixed byte budget (16 bytes by default), so the number of words they can hold shrinks as the word grows. A queued mode can be turned off, leaving a single-word buffer. Every register can be written whole, or have chosen bits cleared, set or inverted through alias addresses, so one field can change without a read-modify-write. The block can drive the active-low select line itself, holding it low while work is pending. A sticky flag records receive words lost because the receive queue was full.

Top module: `spi_efifo_master`

## Requirements
- R1: The address is a word index. Bits 4:2 choose the register (0 control, 1 status, 2 data, 3 divider, 4 auxiliary control). Bits 1:0 choose the write action: 0 replaces the value, 1 clears the bits written as one, 2 sets them, 3 inverts them. The divider holds 9 bits, and the auxiliary control register holds 32 stored bits.
- R2: Control bits 11:10 select the width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. Bits go out most significant first. A read of the data register pops the oldest received word and returns only the low bits of the current width, with the rest zero.
- R3: With control bit 16 set, each queue holds 16, 8 or 4 words for the three widths. With it clear, each queue holds one word. A write that finds the transmit queue full is dropped. Status bits 20:16 give the transmit level and bits 28:24 give the receive level.
- R4: The idle level of the serial clock equals control bit 6. Each word produces two clock transitions per bit. With control bit 8 set, output data changes only on active-to-idle transitions. With it clear, output data changes only on idle-to-active transitions.
- R5: Each half period of the serial clock lasts divider+1 cycles. A word written into an empty, idle block appears in the receive level 1 + 2·(divider+1)·width cycles after its write is accepted.
- R6: Control bit 9 picks sampling in the middle (0) or at the end (1) of each bit. With the input line looped back to the output, every word is received unchanged under all eight clock settings.
- R7: If a word finishes while the receive queue is full, that word is dropped, status bit 6 is set, and shifting carries on. The flag stays set until software clears it, for example through the status clear alias.
- R8: With control bit 28 set and the block on, the select output is low whenever the transmit queue is non-empty or a word is shifting, and high otherwise. With bit 28 clear, it stays high.
- R9: Control bit 15 switches the block on. While it is clear, both queues are empty, shifting stops, and the clock rests at its idle level. Shifting also requires control bit 5.
- R10: After reset, every register reads zero, the select output is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue when the data register is selected) |
| bus_addr | input | 5 | Word address: register slot and write action |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low slave select |

## Verification
A wrong bit counter or half-period counter shows up at once as a wrong number of clock transitions per word, and as a receive level that rises in the wrong cycle. The bench counts both for every width, clock setting and divider. A misaligned transmit shifter shows up within the first word as a corrupted looped-back value, or as a wrong bit captured on the leading edge. Queue capacity or overflow faults change the status levels and the sticky flag within a few cycles of the limit being reached. Faults in the select and on/off logic show on the select and clock pins in the cycle after the triggering write.

// File: rtl/spi_efifo_pkg.sv
package spi_efifo_pkg;
  localparam int unsigned XW = 32;

  // control bit positions
  localparam int unsigned CB_MSTEN = 5;
  localparam int unsigned CB_CKP   = 6;
  localparam int unsigned CB_CKE   = 8;
  localparam int unsigned CB_SMP   = 9;
  localparam int unsigned CB_WLO   = 10;
  localparam int unsigned CB_ON    = 15;
  localparam int unsigned CB_ENH   = 16;
  localparam int unsigned CB_SSEN  = 28;
  // status bit positions
  localparam int unsigned SB_ROV   = 6;
  localparam int unsigned SB_TXL   = 16;
  localparam int unsigned SB_RXL   = 24;

  typedef enum logic [2:0] {SL_CTRL = 3'd0, SL_STAT = 3'd1, SL_BUF = 3'd2,
                            SL_BAUD = 3'd3, SL_CTRL2 = 3'd4} slot_e;
  typedef enum logic [1:0] {OP_PUT = 2'd0, OP_CLR = 2'd1, OP_SET = 2'd2,
                            OP_INV = 2'd3} op_e;

  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 6'd16;
      2'd2:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction

  function automatic logic [XW-1:0] width_mask(input logic [1:0] code);
    case (code)
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  // capacity in words of a queue holding 'bytes' bytes
  function automatic int unsigned fifo_cap(input int unsigned bytes,
                                           input logic enh, input logic [1:0] code);
    if (!enh) return 1;
    case (code)
      2'd1:    return (bytes + 1) / 2;
      2'd2:    return (bytes + 3) / 4;
      default: return bytes;
    endcase
  endfunction

  function automatic logic [XW-1:0] alias_word(input logic [XW-1:0] old,
                                               input logic [XW-1:0] wd, input op_e op);
    case (op)
      OP_PUT:  return wd;
      OP_CLR:  return old & ~wd;
      OP_SET:  return old | wd;
      default: return old ^ wd;
    endcase
  endfunction

  function automatic logic alias_bit(input logic old, input logic wd, input op_e op);
    case (op)
      OP_PUT:  return wd;
      OP_CLR:  return old & ~wd;
      OP_SET:  return old | wd;
      default: return old ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/spi_efifo_queue.sv
module spi_efifo_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [$clog2(DEPTH+1)-1:0]   cap,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt < cap) && !flush;
  assign do_pop  = pop && (cnt != '0) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign level = cnt;
endmodule

// File: rtl/spi_efifo_shifter.sv
module spi_efifo_shifter
  import spi_efifo_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          tx_avail,
  input  logic [XW-1:0] tx_word,
  input  logic [1:0]    code,
  input  logic [8:0]    baud,
  input  logic          ckp,
  input  logic          cke,
  input  logic          smp,
  input  logic          miso,
  output logic          take,
  output logic          done,
  output logic [XW-1:0] rx_word,
  output logic          busy,
  output logic          sclk,
  output logic          mosi
);
  logic [XW-1:0] txsr, rxsr, rx_shift;
  logic [8:0]    hcnt;
  logic [5:0]    bitcnt, nb;
  logic          half, half_end, last_bit, sample_now, act;

  assign nb         = word_bits(code);
  assign last_bit   = (bitcnt == nb - 6'd1);
  assign half_end   = busy && (hcnt == baud);
  assign sample_now = half_end && (half ? smp : !smp);
  assign rx_shift   = {rxsr[XW-2:0], miso};
  assign done       = half_end && half && last_bit;
  assign rx_word    = sample_now ? rx_shift : rxsr;
  assign take       = go && !busy && tx_avail;

  // half 0 is the idle level when data changes on the active-to-idle edge
  assign act  = half ? cke : !cke;
  assign sclk = ckp ^ (busy & act);
  assign mosi = busy & txsr[XW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      half   <= 1'b0;
      hcnt   <= '0;
      bitcnt <= '0;
      txsr   <= '0;
      rxsr   <= '0;
    end else if (!go) begin
      busy <= 1'b0;
      half <= 1'b0;
      hcnt <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      half   <= 1'b0;
      hcnt   <= '0;
      bitcnt <= '0;
      txsr   <= tx_word << (6'd32 - nb);
      rxsr   <= '0;
    end else if (busy) begin
      if (half_end) begin
        hcnt <= '0;
        if (sample_now) rxsr <= rx_shift;
        if (half) begin
          half   <= 1'b0;
          txsr   <= txsr << 1;
          bitcnt <= bitcnt + 6'd1;
          if (last_bit) busy <= 1'b0;
        end else begin
          half <= 1'b1;
        end
      end else begin
        hcnt <= hcnt + 9'd1;
      end
    end
  end
endmodule

// File: rtl/spi_efifo_master.sv
module spi_efifo_master
  import spi_efifo_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_ss_n
);
  localparam int unsigned LW = $clog2(FIFO_BYTES + 1);

  slot_e slot;
  op_e   op;
  assign slot = slot_e'(bus_addr[4:2]);
  assign op   = op_e'(bus_addr[1:0]);

  logic [XW-1:0] ctrl_q, ctrl2_q;
  logic [8:0]    baud_q, baud_nx;
  logic          rov_q;

  // named events for the checker
  logic stat_wr, ovf_evt, tx_push, rx_pop, rx_push, rx_full, tx_ready;
  logic mod_on, ctrl_ckp, ss_en, sh_go;
  logic [LW-1:0] tx_lvl, rx_lvl, cap;
  logic [XW-1:0] tx_head, rx_head, sh_word;
  logic sh_take, sh_done, sh_busy;

  assign stat_wr  = bus_wr && (slot == SL_STAT);
  assign tx_push  = bus_wr && (slot == SL_BUF) && (op == OP_PUT);
  assign rx_pop   = bus_rd && (slot == SL_BUF);
  assign mod_on   = ctrl_q[CB_ON];
  assign ctrl_ckp = ctrl_q[CB_CKP];
  assign ss_en    = ctrl_q[CB_SSEN];
  assign sh_go    = mod_on && ctrl_q[CB_MSTEN];
  assign cap      = LW'(fifo_cap(FIFO_BYTES, ctrl_q[CB_ENH], ctrl_q[CB_WLO+1:CB_WLO]));
  assign tx_ready = (tx_lvl != '0);
  assign rx_full  = (rx_lvl >= cap);
  assign ovf_evt  = sh_done && rx_full;
  assign rx_push  = sh_done && !rx_full;

  for (genvar i = 0; i < 9; i++) begin : g_baud
    assign baud_nx[i] = alias_bit(baud_q[i], bus_wdata[i], op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ctrl2_q <= '0;
      baud_q  <= '0;
      rov_q   <= 1'b0;
    end else begin
      if (bus_wr && slot == SL_CTRL)  ctrl_q  <= alias_word(ctrl_q, bus_wdata, op);
      if (bus_wr && slot == SL_CTRL2) ctrl2_q <= alias_word(ctrl2_q, bus_wdata, op);
      if (bus_wr && slot == SL_BAUD)  baud_q  <= baud_nx;
      if (ovf_evt)      rov_q <= 1'b1;
      else if (stat_wr) rov_q <= alias_bit(rov_q, bus_wdata[SB_ROV], op);
    end
  end

  spi_efifo_queue #(.DEPTH(FIFO_BYTES), .W(XW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!mod_on), .cap(cap),
    .push(tx_push), .wdata(bus_wdata), .pop(sh_take),
    .rdata(tx_head), .level(tx_lvl));

  spi_efifo_queue #(.DEPTH(FIFO_BYTES), .W(XW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!mod_on), .cap(cap),
    .push(rx_push), .wdata(sh_word), .pop(rx_pop),
    .rdata(rx_head), .level(rx_lvl));

  spi_efifo_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_avail(tx_ready),
    .tx_word(tx_head), .code(ctrl_q[CB_WLO+1:CB_WLO]), .baud(baud_q),
    .ckp(ctrl_ckp), .cke(ctrl_q[CB_CKE]), .smp(ctrl_q[CB_SMP]),
    .miso(spi_miso), .take(sh_take), .done(sh_done), .rx_word(sh_word),
    .busy(sh_busy), .sclk(spi_sclk), .mosi(spi_mosi));

  assign spi_ss_n = !(ss_en && mod_on && (tx_ready || sh_busy));

  always_comb begin
    bus_rdata = '0;
    case (slot)
      SL_CTRL:  bus_rdata = ctrl_q;
      SL_STAT: begin
        bus_rdata[SB_ROV]        = rov_q;
        bus_rdata[SB_TXL +: LW]  = tx_lvl;
        bus_rdata[SB_RXL +: LW]  = rx_lvl;
      end
      SL_BUF:   bus_rdata = rx_head & width_mask(ctrl_q[CB_WLO+1:CB_WLO]);
      SL_BAUD:  bus_rdata[8:0] = baud_q;
      SL_CTRL2: bus_rdata = ctrl2_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_efifo_checker.sv
module spi_efifo_checker #(
  parameter int unsigned LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_on,
  input logic          ckp,
  input logic          ss_en,
  input logic          stat_wr,
  input logic          ovf_evt,
  input logic          rov_q,
  input logic          sclk,
  input logic          ss_n,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic [LW-1:0] cap
);
  AST_OFF_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_on && $past(!mod_on)) |-> (sclk == ckp)); // R9
  AST_OFF_QUEUES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_on |=> (tx_lvl == '0 && rx_lvl == '0)); // R9
  AST_TX_NO_GROWTH_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl >= cap) |=> (tx_lvl <= $past(tx_lvl))); // R3
  AST_OVERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> rov_q); // R7
  AST_OVERFLOW_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (rx_lvl <= $past(rx_lvl))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rov_q && !stat_wr) |=> rov_q); // R7
  AST_SELECT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> (ss_en && mod_on)); // R8
  AST_SELECT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl != '0 && ss_en && mod_on) |-> !ss_n); // R8
endmodule

bind spi_efifo_master spi_efifo_checker #(.LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mod_on(mod_on), .ckp(ctrl_ckp), .ss_en(ss_en),
  .stat_wr(stat_wr), .ovf_evt(ovf_evt), .rov_q(rov_q), .sclk(spi_sclk),
  .ss_n(spi_ss_n), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .cap(cap));

// File: tb/spi_efifo_master_tb_top.sv
module spi_efifo_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'd0, A_STAT = 5'd4, A_BUF = 5'd8,
                         A_BAUD = 5'd12, A_CTRL2 = 5'd16;
  localparam logic [31:0] K_MST = 32'h20, K_ON = 32'h8000, K_ENH = 32'h1_0000,
                          K_SS = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, spi_ss_n;
  int n_tests = 0, n_fail = 0;

  assign spi_miso = spi_mosi;
  always #(CLK_PERIOD/2) clk = ~clk;

  spi_efifo_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_ss_n(spi_ss_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic popit, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = popit;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(A_CTRL, 0, r);  check("R10 ctrl", r, 0);
    rd(A_STAT, 0, r);  check("R10 stat", r, 0);
    rd(A_BAUD, 0, r);  check("R10 baud", r, 0);
    rd(A_CTRL2, 0, r); check("R10 ctrl2", r, 0);
    check("R10 sclk", {31'b0, spi_sclk}, 0);
    check("R10 ss_n", {31'b0, spi_ss_n}, 1);

    // R1 write actions
    wr(A_CTRL2, 32'hF0F0_00FF);     rd(A_CTRL2, 0, r); check("R1 put", r, 32'hF0F0_00FF);
    wr(A_CTRL2 + 1, 32'h0000_000F); rd(A_CTRL2, 0, r); check("R1 clr", r, 32'hF0F0_00F0);
    wr(A_CTRL2 + 2, 32'h0F00_0000); rd(A_CTRL2, 0, r); check("R1 set", r, 32'hFFF0_00F0);
    wr(A_CTRL2 + 3, 32'hFFFF_0000); rd(A_CTRL2, 0, r); check("R1 inv", r, 32'h000F_00F0);
    wr(A_BAUD, 32'hFFFF_FFFF);      rd(A_BAUD, 0, r);  check("R1 baud width", r, 32'h1FF);
    wr(A_BAUD + 1, 32'h100);        rd(A_BAUD, 0, r);  check("R1 baud clr", r, 32'h0FF);
    wr(A_BAUD + 3, 32'h3);          rd(A_BAUD, 0, r);  check("R1 baud inv", r, 32'h0FC);
    wr(A_BAUD, 0);

    // R3 capacity sweep, shifting disabled (R9 master enable clear)
    for (int enh = 0; enh < 2; enh++) begin
      for (int code = 0; code < 3; code++) begin
        int expc;
        expc = enh ? (16 >> code) : 1;
        wr(A_CTRL, K_ON | (enh ? K_ENH : 0) | (32'(code) << 10));
        for (int k = 0; k < 20; k++) wr(A_BUF, 32'(k));
        rd(A_STAT, 0, r);
        check("R3 tx level at capacity", 32'(r[20:16]), 32'(expc));
        check("R9 no shift without master enable", 32'(r[28:24]), 0);
        wr(A_CTRL + 1, K_ON);
        rd(A_STAT, 0, r);
        check("R9 off flushes", r, 0);
      end
    end

    // R2 R4 R5 R6 loopback sweep
    for (int code = 0; code < 3; code++) begin
      for (int mode = 0; mode < 8; mode++) begin
        for (int bi = 0; bi < 2; bi++) begin
          int nb, b, n, tog, bad;
          logic [31:0] word, mask, capw, cv;
          logic ckp, cke, prev_s, prev_m, mchg;
          nb = 8 << code; b = bi * 3;
          ckp = mode[0]; cke = mode[1];
          mask = (code == 2) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
          word = 32'h9E37_79B9 * 32'(code * 16 + mode * 2 + bi + 1);
          cv = K_ON | K_MST | K_ENH | (32'(code) << 10) | (32'(mode & 1) << 6)
             | (32'((mode >> 1) & 1) << 8) | (32'((mode >> 2) & 1) << 9);
          wr(A_CTRL, cv);
          wr(A_BAUD, 32'(b));
          wr(A_BUF, word);
          bus_addr = A_STAT;
          n = 0; tog = 0; bad = 0; capw = 0;
          prev_s = spi_sclk; prev_m = spi_mosi;
          while (n < 2000) begin
            @(posedge clk); @(negedge clk);
            n++;
            mchg = (spi_mosi !== prev_m);
            if (spi_sclk !== prev_s) begin
              tog++;
              if (prev_s === ckp) begin
                capw = {capw[30:0], spi_mosi};
                if (cke && mchg) bad++;
              end else if (!cke && mchg) bad++;
            end
            prev_s = spi_sclk; prev_m = spi_mosi;
            if (bus_rdata[28:24] != 0) break;
          end
          check("R5 word latency", 32'(n), 32'(1 + 2 * (b + 1) * nb));
          check("R4 clock transitions", 32'(tog), 32'(2 * nb));
          check("R4 data edge", 32'(bad), 0);
          check("R4 idle level", {31'b0, spi_sclk}, {31'b0, ckp});
          check("R2 msb first", capw & mask, word & mask);
          rd(A_BUF, 1, r);
          check("R6 loopback word", r, word & mask);
        end
      end
    end

    // R7 overflow: 17 bytes into a 16-byte receive queue
    wr(A_CTRL, K_ON | K_MST | K_ENH);
    wr(A_BAUD, 0);
    for (int k = 0; k < 17; k++) wr(A_BUF, 32'h10 + 32'(k));
    repeat (400) @(negedge clk);
    rd(A_STAT, 0, r);
    check("R7 flag set", 32'(r[6]), 1);
    check("R7 rx full", 32'(r[28:24]), 16);
    check("R7 tx drained", 32'(r[20:16]), 0);
    repeat (50) @(negedge clk);
    rd(A_STAT, 0, r); check("R7 flag sticky", 32'(r[6]), 1);
    for (int k = 0; k < 16; k++) begin
      rd(A_BUF, 1, r);
      check("R7 kept words", r, 32'h10 + 32'(k));
    end
    rd(A_STAT, 0, r); check("R7 flag survives reads", r, 32'h40);
    wr(A_STAT + 1, 32'h40);
    rd(A_STAT, 0, r); check("R7 flag cleared", r, 0);

    // R8 hardware select
    begin
      int hi_cnt, guard;
      wr(A_CTRL, K_ON | K_MST | K_ENH | K_SS);
      wr(A_BAUD, 1);
      check("R8 idle high", {31'b0, spi_ss_n}, 1);
      wr(A_BUF, 32'hA5);
      check("R8 low after write", {31'b0, spi_ss_n}, 0);
      wr(A_BUF, 32'h3C);
      bus_addr = A_STAT;
      hi_cnt = 0; guard = 0;
      while (bus_rdata[28:24] != 2 && guard < 500) begin
        @(posedge clk); @(negedge clk); guard++;
        if (spi_ss_n && bus_rdata[28:24] != 2) hi_cnt++;
      end
      check("R8 held low through words", 32'(hi_cnt), 0);
      check("R8 released when done", {31'b0, spi_ss_n}, 1);
      rd(A_BUF, 1, r); check("R8 word one", r, 32'hA5);
      rd(A_BUF, 1, r); check("R8 word two", r, 32'h3C);
      wr(A_CTRL + 1, K_SS);
      wr(A_BUF, 32'h5A);
      bus_addr = A_STAT;
      hi_cnt = 0; guard = 0;
      while (bus_rdata[28:24] == 0 && guard < 500) begin
        @(posedge clk); @(negedge clk); guard++;
        if (!spi_ss_n) hi_cnt++;
      end
      check("R8 disabled stays high", 32'(hi_cnt), 0);
      rd(A_BUF, 1, r);
    end

    // R9 switching off mid-word
    wr(A_CTRL, K_ON | K_MST | K_ENH | 32'h40 | (32'd2 << 10));
    wr(A_BAUD, 3);
    wr(A_BUF, 32'hDEAD_BEEF);
    wr(A_BUF, 32'h1234_5678);
    repeat (20) @(negedge clk);
    wr(A_CTRL + 1, K_ON);
    check("R9 sclk idle when off", {31'b0, spi_sclk}, 1);
    check("R9 mosi quiet when off", {31'b0, spi_mosi}, 0);
    rd(A_STAT, 0, r); check("R9 queues flushed", r, 0);
    wr(A_CTRL + 2, K_ON);
    repeat (300) @(negedge clk);
    rd(A_STAT, 0, r); check("R9 nothing resumes", r, 0);

    finish_run();
  end
endmodule